// File: doc/BRIEF.md
# Masked Alarm and Interrupt Router

This block decides when a time-of-day alarm has occurred and routes that event and a watchdog expiry event onto two interrupt lines. It holds three BCD alarm registers (minutes, hours, day of week). Each carries a mask bit in bit 7, and the mask bits set how much of the time must match. It also holds a command register that selects which event drives which line, masks each line, sets the drive polarity of the second line, and chooses between held-level and timed-pulse signalling.

The surrounding timekeeper gives the block a check strobe once per second, during the last hundredth of that second. With the strobe it gives the seconds, minutes, hours and day values that take effect at the coming rollover. The watchdog gives a one-cycle expiry event. A 1024 Hz enable times the pulses. Software reaches the registers through a simple single-cycle bus. An access to an alarm register clears the alarm flag, and an access to a watchdog register offset (0xC or 0xD) clears the watchdog flag. Each interrupt line is modelled as a drive enable. The second line also has a polarity output.

Top module: `alarm_irq_router`

## Requirements
- R1: The alarm registers are at offset 0x3 (minutes), 0x5 (hours) and 0x7 (day), and the command register is at 0xB. All four are readable and writable. Bits 6..3 of the day register always read 0, and any other offset reads 0x00. After reset every register reads 0x00.
- R2: An alarm fires only at a strobe whose seconds value is 0x00. With the mask bits (day, hour, minute) at 000, it fires when minutes[6:0], hours[6:0] and day[2:0] all match. Any mask pattern other than 000, 100, 110 and 111 also behaves as this exact match.
- R3: With only the day mask set (pattern 100), the alarm fires when minutes and hours match, whatever the day.
- R4: With the day and hour masks set (pattern 110), the alarm fires when minutes match.
- R5: With all three masks set, the alarm fires at every strobe whose seconds value is 0x00. No alarm fires at a strobe whose seconds value is not 0x00.
- R6: Command bit 0 is the alarm flag and is read-only. It reads 1 from the cycle after a firing strobe. Any read or write of offset 0x3, 0x5 or 0x7 clears it. If a firing strobe and such an access fall in the same cycle, the flag is set.
- R7: Command bit 1 is the watchdog flag and is read-only. It reads 1 from the cycle after an expiry event. Any access to offset 0xC or 0xD clears it, and an expiry in the same cycle wins. Accesses to other offsets leave it unchanged.
- R8: When command bit 2 is 1, the alarm flag drives no line. When command bit 3 is 1, the watchdog flag drives no line. In both cases the flag itself still sets and reads back.
- R9: When command bit 6 is 1, inta_drv carries the alarm and intb_drv carries the watchdog. When it is 0, the two are exchanged.
- R10: When command bit 4 is 1 (pulse mode), a flag falls by itself at the fourth 1024 Hz tick after it was set, and so does its line. When bit 4 is 0, a flag stays set until it is cleared.
- R11: intb_src equals command bit 5 (1 means the second line sources current when active, 0 means it sinks). Command bits 7..2 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle 1024 Hz enable for pulse timing |
| chk_stb | input | 1 | Alarm check strobe, once per second |
| nxt_sec | input | 8 | Seconds value after the coming rollover (BCD) |
| nxt_min | input | 8 | Minutes value after the coming rollover (BCD) |
| nxt_hour | input | 8 | Hours value after the coming rollover, including format bits |
| nxt_day | input | 8 | Day of week after the coming rollover |
| wd_expire | input | 1 | One-cycle watchdog expiry event |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| inta_drv | output | 1 | First interrupt line active |
| intb_drv | output | 1 | Second interrupt line active |
| intb_src | output | 1 | Second line polarity: 1 source, 0 sink |

## Verification
The assertions assume that chk_stb, wd_expire and tick_1k are single-cycle pulses sampled at the rising edge, and that bus_addr is valid whenever bus_sel is high. The pulse-hold property also assumes that a flag is not set again by a new event while its pulse counts down. The stimulus changes every input on the falling clock edge and holds each strobe, expiry and access for exactly one cycle. It spaces ticks ten cycles apart, so a pulse lasts about forty cycles. It lets each pulse run out before the next event on the same flag, except in the one test where an event and a clearing access are placed in the same cycle on purpose.

// File: rtl/alrm_pkg.sv
package alrm_pkg;

    localparam int REG_W = 8;

    localparam logic [3:0] OFS_MIN_AL = 4'h3;
    localparam logic [3:0] OFS_HR_AL  = 4'h5;
    localparam logic [3:0] OFS_DAY_AL = 4'h7;
    localparam logic [3:0] OFS_CMD    = 4'hB;
    localparam logic [3:0] OFS_WD_LO  = 4'hC;
    localparam logic [3:0] OFS_WD_HI  = 4'hD;

    typedef enum logic [1:0] {
        CMP_EXACT  = 2'd0,
        CMP_DAILY  = 2'd1,
        CMP_HOURLY = 2'd2,
        CMP_MINUTE = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic [REG_W-1:0] min_al;
        logic [REG_W-1:0] hr_al;
        logic [REG_W-1:0] day_al;
        logic             cmd_b7;
        logic             swap;
        logic             b_src;
        logic             pulse;
        logic             wd_mask;
        logic             tod_mask;
    } regs_t;

    localparam int CH_TOD = 0;
    localparam int CH_WD  = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/alrm_match.sv
module alrm_match
    import alrm_pkg::*;
(
    input  logic [REG_W-1:0] min_al,
    input  logic [REG_W-1:0] hr_al,
    input  logic [REG_W-1:0] day_al,
    input  logic             chk_stb,
    input  logic [REG_W-1:0] nxt_sec,
    input  logic [REG_W-1:0] nxt_min,
    input  logic [REG_W-1:0] nxt_hour,
    input  logic [REG_W-1:0] nxt_day,
    output logic             hit
);

    cmp_mode_e mode;
    logic      min_eq;
    logic      hr_eq;
    logic      day_eq;
    logic      want;

    always_comb begin
        unique case ({day_al[7], hr_al[7], min_al[7]})
            3'b100:  mode = CMP_DAILY;
            3'b110:  mode = CMP_HOURLY;
            3'b111:  mode = CMP_MINUTE;
            default: mode = CMP_EXACT;
        endcase
    end

    always_comb begin
        min_eq = (nxt_min[6:0] == min_al[6:0]);
        hr_eq  = (nxt_hour[6:0] == hr_al[6:0]);
        day_eq = (nxt_day[6:0] == {4'b0000, day_al[2:0]});
        unique case (mode)
            CMP_MINUTE: want = 1'b1;
            CMP_HOURLY: want = min_eq;
            CMP_DAILY:  want = min_eq & hr_eq;
            default:    want = min_eq & hr_eq & day_eq;
        endcase
        hit = chk_stb & (nxt_sec == '0) & want;
    end

endmodule

// File: rtl/irq_chan.sv
module irq_chan #(
    parameter int PULSE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic pulse_i,
    input  logic tick_i,
    output logic flag_o
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t st_d;
    chan_t st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
            st_d.cnt  = CNT_W'(PULSE_TICKS);
        end else if (clr_i) begin
            st_d.flag = 1'b0;
            st_d.cnt  = '0;
        end else if (pulse_i && st_q.flag && tick_i) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.flag = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/irq_route.sv
module irq_route (
    input  logic tod_req,
    input  logic wd_req,
    input  logic swap,
    output logic line_a,
    output logic line_b
);

    always_comb begin
        if (swap) begin
            line_a = tod_req;
            line_b = wd_req;
        end else begin
            line_a = wd_req;
            line_b = tod_req;
        end
    end

endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
    import alrm_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PULSE_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1k,
    input  logic              chk_stb,
    input  logic [REG_W-1:0]  nxt_sec,
    input  logic [REG_W-1:0]  nxt_min,
    input  logic [REG_W-1:0]  nxt_hour,
    input  logic [REG_W-1:0]  nxt_day,
    input  logic              wd_expire,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              inta_drv,
    output logic              intb_drv,
    output logic              intb_src
);

    regs_t r_d;
    regs_t r_q;

    logic            alarm_hit;
    logic            tod_acc;
    logic            wd_acc;
    logic [N_CH-1:0] ch_set;
    logic [N_CH-1:0] ch_clr;
    logic [N_CH-1:0] ch_flag;
    logic            tod_flag;
    logic            wd_flag;
    logic            tod_req;
    logic            wd_req;

    function automatic logic at(input logic [ADDR_W-1:0] a, input logic [3:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign tod_acc = bus_sel & (at(bus_addr, OFS_MIN_AL) | at(bus_addr, OFS_HR_AL) |
                                at(bus_addr, OFS_DAY_AL));
    assign wd_acc  = bus_sel & (at(bus_addr, OFS_WD_LO) | at(bus_addr, OFS_WD_HI));

    always_comb begin
        r_d = r_q;
        if (bus_sel && bus_wr) begin
            if (at(bus_addr, OFS_MIN_AL)) r_d.min_al = bus_wdata;
            if (at(bus_addr, OFS_HR_AL))  r_d.hr_al  = bus_wdata;
            if (at(bus_addr, OFS_DAY_AL)) r_d.day_al = {bus_wdata[7], 4'b0000, bus_wdata[2:0]};
            if (at(bus_addr, OFS_CMD)) begin
                r_d.cmd_b7   = bus_wdata[7];
                r_d.swap     = bus_wdata[6];
                r_d.b_src    = bus_wdata[5];
                r_d.pulse    = bus_wdata[4];
                r_d.wd_mask  = bus_wdata[3];
                r_d.tod_mask = bus_wdata[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    alrm_match u_match (
        .min_al   (r_q.min_al),
        .hr_al    (r_q.hr_al),
        .day_al   (r_q.day_al),
        .chk_stb  (chk_stb),
        .nxt_sec  (nxt_sec),
        .nxt_min  (nxt_min),
        .nxt_hour (nxt_hour),
        .nxt_day  (nxt_day),
        .hit      (alarm_hit)
    );

    assign ch_set[CH_TOD] = alarm_hit;
    assign ch_set[CH_WD]  = wd_expire;
    assign ch_clr[CH_TOD] = tod_acc;
    assign ch_clr[CH_WD]  = wd_acc;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        irq_chan #(
            .PULSE_TICKS (PULSE_TICKS)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (ch_set[i]),
            .clr_i   (ch_clr[i]),
            .pulse_i (r_q.pulse),
            .tick_i  (tick_1k),
            .flag_o  (ch_flag[i])
        );
    end

    assign tod_flag = ch_flag[CH_TOD];
    assign wd_flag  = ch_flag[CH_WD];
    assign tod_req  = tod_flag & ~r_q.tod_mask;
    assign wd_req   = wd_flag & ~r_q.wd_mask;

    irq_route u_route (
        .tod_req (tod_req),
        .wd_req  (wd_req),
        .swap    (r_q.swap),
        .line_a  (inta_drv),
        .line_b  (intb_drv)
    );

    assign intb_src = r_q.b_src;

    always_comb begin
        bus_rdata = '0;
        if (at(bus_addr, OFS_MIN_AL)) bus_rdata = r_q.min_al;
        if (at(bus_addr, OFS_HR_AL))  bus_rdata = r_q.hr_al;
        if (at(bus_addr, OFS_DAY_AL)) bus_rdata = r_q.day_al;
        if (at(bus_addr, OFS_CMD)) begin
            bus_rdata = {r_q.cmd_b7, r_q.swap, r_q.b_src, r_q.pulse,
                         r_q.wd_mask, r_q.tod_mask, wd_flag, tod_flag};
        end
    end

endmodule

// File: rtl/alrm_router_chk.sv
module alrm_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1k,
    input logic       chk_stb,
    input logic [7:0] nxt_sec,
    input logic       wd_expire,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       inta_drv,
    input logic       intb_drv,
    input logic       alarm_hit,
    input logic       tod_flag,
    input logic       wd_flag,
    input logic       cmd_swap,
    input logic       cmd_pulse,
    input logic       cmd_tod_mask,
    input logic       cmd_wd_mask
);

    logic al_acc;
    assign al_acc = bus_sel && (bus_addr == 4'h3 || bus_addr == 4'h5 || bus_addr == 4'h7);

    p_day_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 4'h7) |-> (bus_rdata[6:3] == 4'b0000));

    p_no_hit_off_rollover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_stb && nxt_sec != 8'h00) |-> !alarm_hit);

    p_hit_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> tod_flag);

    p_access_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (al_acc && !alarm_hit) |=> !tod_flag);

    p_wd_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> wd_flag);

    p_masks_silence_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tod_mask && cmd_wd_mask) |-> (!inta_drv && !intb_drv));

    p_swap_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_flag && !cmd_tod_mask && cmd_swap) |-> inta_drv);

    p_pulse_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && tod_flag && !tick_1k && !al_acc) |=> tod_flag);

    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pulse && wd_flag && !(bus_sel && (bus_addr == 4'hC || bus_addr == 4'hD))) |=> wd_flag);

endmodule

bind alarm_irq_router alrm_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_1k      (tick_1k),
    .chk_stb      (chk_stb),
    .nxt_sec      (nxt_sec),
    .wd_expire    (wd_expire),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .inta_drv     (inta_drv),
    .intb_drv     (intb_drv),
    .alarm_hit    (alarm_hit),
    .tod_flag     (tod_flag),
    .wd_flag      (wd_flag),
    .cmd_swap     (r_q.swap),
    .cmd_pulse    (r_q.pulse),
    .cmd_tod_mask (r_q.tod_mask),
    .cmd_wd_mask  (r_q.wd_mask)
);

// File: tb/alarm_irq_router_test.sv
module alarm_irq_router_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1k = 1'b0;
    logic       chk_stb = 1'b0;
    logic [7:0] nxt_sec = 8'h00;
    logic [7:0] nxt_min = 8'h00;
    logic [7:0] nxt_hour = 8'h00;
    logic [7:0] nxt_day = 8'h00;
    logic       wd_expire = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       inta_drv;
    logic       intb_drv;
    logic       intb_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    alarm_irq_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1k   (tick_1k),
        .chk_stb   (chk_stb),
        .nxt_sec   (nxt_sec),
        .nxt_min   (nxt_min),
        .nxt_hour  (nxt_hour),
        .nxt_day   (nxt_day),
        .wd_expire (wd_expire),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .inta_drv  (inta_drv),
        .intb_drv  (intb_drv),
        .intb_src  (intb_src)
    );

    always #5 clk = ~clk;

    // reference model state
    logic [7:0] m_min, m_hr, m_day;
    logic [5:0] m_cmd;
    bit         m_tf, m_wf;
    int         m_ct, m_cw;

    function automatic bit m_alarm();
        bit dm, hm, mm, me, he, de;
        dm = m_day[7]; hm = m_hr[7]; mm = m_min[7];
        me = (nxt_min[6:0] == m_min[6:0]);
        he = (nxt_hour[6:0] == m_hr[6:0]);
        de = (nxt_day[6:0] == {4'b0000, m_day[2:0]});
        if (!chk_stb || nxt_sec != 8'h00) return 0;
        if (dm && hm && mm) return 1;
        if (dm && hm && !mm) return me;
        if (dm && !hm && !mm) return me && he;
        return me && he && de;
    endfunction

    function automatic logic [7:0] m_rd(input logic [3:0] a);
        case (a)
            4'h3: return m_min;
            4'h5: return m_hr;
            4'h7: return m_day;
            4'hB: return {m_cmd, m_wf, m_tf};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_min = 0; m_hr = 0; m_day = 0; m_cmd = 0;
            m_tf = 0; m_wf = 0; m_ct = 0; m_cw = 0;
        end else begin
            bit fire, tacc, wacc, pm;
            fire = m_alarm();
            tacc = bus_sel && (bus_addr == 4'h3 || bus_addr == 4'h5 || bus_addr == 4'h7);
            wacc = bus_sel && (bus_addr == 4'hC || bus_addr == 4'hD);
            pm = m_cmd[2];
            if (fire) begin m_tf = 1; m_ct = 4; end
            else if (tacc) begin m_tf = 0; m_ct = 0; end
            else if (pm && m_tf && tick_1k) begin
                if (m_ct <= 1) begin m_tf = 0; m_ct = 0; end else m_ct--;
            end
            if (wd_expire) begin m_wf = 1; m_cw = 4; end
            else if (wacc) begin m_wf = 0; m_cw = 0; end
            else if (pm && m_wf && tick_1k) begin
                if (m_cw <= 1) begin m_wf = 0; m_cw = 0; end else m_cw--;
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    4'h3: m_min = bus_wdata;
                    4'h5: m_hr = bus_wdata;
                    4'h7: m_day = {bus_wdata[7], 4'b0000, bus_wdata[2:0]};
                    4'hB: m_cmd = bus_wdata[7:2];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // tick generator: one cycle every ten
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 9) ? 0 : tdiv + 1;
        tick_1k <= (tdiv == 0);
    end

    // per-cycle comparison of the interrupt outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ti, wi, ea, eb;
            ti = m_tf && !m_cmd[0];
            wi = m_wf && !m_cmd[1];
            ea = m_cmd[4] ? ti : wi;
            eb = m_cmd[4] ? wi : ti;
            chk(inta_drv == ea, "R9 inta_drv route/mask (R8 R10)", inta_drv, ea);
            chk(intb_drv == eb, "R9 intb_drv route/mask (R8 R10)", intb_drv, eb);
            chk(intb_src == m_cmd[3], "R11 intb_src", intb_src, m_cmd[3]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    // read; checks against model and optional literal mask/value
    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(bus_rdata == m_rd(a), tag, bus_rdata, m_rd(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_lit(input logic [3:0] a, input logic [7:0] msk,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk((bus_rdata & msk) == exp, tag, bus_rdata & msk, exp);
        chk(bus_rdata == m_rd(a), tag, bus_rdata, m_rd(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic stb(input logic [7:0] s, input logic [7:0] mi,
                       input logic [7:0] h, input logic [7:0] d);
        @(negedge clk);
        chk_stb = 1; nxt_sec = s; nxt_min = mi; nxt_hour = h; nxt_day = d;
        @(negedge clk);
        chk_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        rd_lit(4'hB, 8'hFF, 8'h00, "R1 reset command");
        rd_lit(4'h3, 8'hFF, 8'h00, "R1 reset minutes alarm");
        // R1 register access
        wr(4'h3, 8'h30); wr(4'h5, 8'h12); wr(4'h7, 8'hFF);
        rd_lit(4'h7, 8'hFF, 8'h87, "R1 day bits 6..3 zero");
        wr(4'h7, 8'h03);
        rd_lit(4'h3, 8'hFF, 8'h30, "R1 minutes readback");
        rd_lit(4'h0, 8'hFF, 8'h00, "R1 unmapped offset");
        // R2 exact
        stb(8'h00, 8'h30, 8'h12, 8'h03);
        rd_lit(4'hB, 8'h01, 8'h01, "R2 exact match fires");
        chk(intb_drv == 1, "R9 swap=0 alarm on line b", intb_drv, 1);
        rd(4'h5, "R6 clearing read");
        rd_lit(4'hB, 8'h01, 8'h00, "R6 flag cleared by alarm read");
        stb(8'h00, 8'h30, 8'h12, 8'h04);
        rd_lit(4'hB, 8'h01, 8'h00, "R2 day mismatch no fire");
        stb(8'h01, 8'h30, 8'h12, 8'h03);
        rd_lit(4'hB, 8'h01, 8'h00, "R5 nonzero seconds no fire");
        // R2 undefined mask pattern (hour mask only)
        wr(4'h5, 8'h92);
        stb(8'h00, 8'h30, 8'h12, 8'h04);
        rd_lit(4'hB, 8'h01, 8'h00, "R2 odd mask still needs day");
        stb(8'h00, 8'h30, 8'h12, 8'h03);
        rd_lit(4'hB, 8'h01, 8'h01, "R2 odd mask exact fires");
        // R3 daily
        wr(4'h5, 8'h12); wr(4'h7, 8'h83);
        stb(8'h00, 8'h30, 8'h12, 8'h05);
        rd_lit(4'hB, 8'h01, 8'h01, "R3 daily ignores day");
        wr(4'h7, 8'h83);
        stb(8'h00, 8'h30, 8'h13, 8'h05);
        rd_lit(4'hB, 8'h01, 8'h00, "R3 daily hour mismatch");
        // R4 hourly
        wr(4'h5, 8'h92);
        stb(8'h00, 8'h30, 8'h07, 8'h01);
        rd_lit(4'hB, 8'h01, 8'h01, "R4 hourly ignores hour");
        wr(4'h5, 8'h92);
        stb(8'h00, 8'h31, 8'h07, 8'h01);
        rd_lit(4'hB, 8'h01, 8'h00, "R4 hourly minute mismatch");
        // R5 every minute
        wr(4'h3, 8'hB0);
        stb(8'h00, 8'h45, 8'h22, 8'h06);
        rd_lit(4'hB, 8'h01, 8'h01, "R5 every minute fires");
        wr(4'h3, 8'hB0);
        stb(8'h30, 8'h45, 8'h22, 8'h06);
        rd_lit(4'hB, 8'h01, 8'h00, "R5 mid-minute no fire");
        // R6 set wins over clear
        @(negedge clk);
        chk_stb = 1; nxt_sec = 8'h00; bus_sel = 1; bus_wr = 0; bus_addr = 4'h3;
        @(negedge clk);
        chk_stb = 0; bus_sel = 0;
        rd_lit(4'hB, 8'h01, 8'h01, "R6 set wins same cycle");
        rd(4'h7, "R6 clear");
        // R7 watchdog flag
        @(negedge clk) wd_expire = 1;
        @(negedge clk) wd_expire = 0;
        rd_lit(4'hB, 8'h02, 8'h02, "R7 expiry sets flag");
        chk(inta_drv == 1, "R9 swap=0 watchdog on line a", inta_drv, 1);
        rd(4'h3, "R7 alarm read");
        rd_lit(4'hB, 8'h02, 8'h02, "R7 alarm access keeps wd flag");
        rd(4'hC, "R7 wd read");
        rd_lit(4'hB, 8'h02, 8'h00, "R7 wd access clears flag");
        // R8 masks
        wr(4'hB, 8'h04);
        stb(8'h00, 8'h11, 8'h11, 8'h01);
        rd_lit(4'hB, 8'h01, 8'h01, "R8 masked flag still sets");
        chk(intb_drv == 0, "R8 masked alarm line idle", intb_drv, 0);
        wr(4'hB, 8'h08);
        chk(intb_drv == 1, "R8 unmasked alarm line active", intb_drv, 1);
        @(negedge clk) wd_expire = 1;
        @(negedge clk) wd_expire = 0;
        chk(inta_drv == 0, "R8 masked watchdog line idle", inta_drv, 0);
        rd(4'hD, "R7 wd clear"); rd(4'h3, "R6 clear");
        // R9 swap and R11 polarity
        wr(4'hB, 8'h40);
        stb(8'h00, 8'h11, 8'h11, 8'h01);
        chk(inta_drv == 1 && intb_drv == 0, "R9 swap=1 alarm on line a",
            {inta_drv, intb_drv}, 2'b10);
        wr(4'hB, 8'hE0);
        chk(intb_src == 1, "R11 source polarity", intb_src, 1);
        rd_lit(4'hB, 8'hFC, 8'hE0, "R11 command readback");
        wr(4'hB, 8'h40);
        chk(intb_src == 0, "R11 sink polarity", intb_src, 0);
        rd(4'h3, "R6 clear");
        // R10 pulse mode
        wr(4'hB, 8'h50);
        stb(8'h00, 8'h11, 8'h11, 8'h01);
        idle(12);
        rd_lit(4'hB, 8'h01, 8'h01, "R10 pulse still active");
        idle(50);
        rd_lit(4'hB, 8'h01, 8'h00, "R10 pulse released");
        chk(inta_drv == 0, "R10 line released", inta_drv, 0);
        @(negedge clk) wd_expire = 1;
        @(negedge clk) wd_expire = 0;
        chk(intb_drv == 1, "R10 watchdog pulse on", intb_drv, 1);
        idle(60);
        rd_lit(4'hB, 8'h02, 8'h00, "R10 watchdog pulse released");
        // R10 level mode holds
        wr(4'hB, 8'h40);
        @(negedge clk) wd_expire = 1;
        @(negedge clk) wd_expire = 0;
        idle(60);
        rd_lit(4'hB, 8'h02, 8'h02, "R10 level mode holds");
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule